// File: doc/BRIEF.md
# Synthesizer frequency word calculator

This block turns a requested pixel-clock period, given in picoseconds, into the 13-bit programming word for a serially loaded clock synthesizer. A request is accepted when `start` is high while `ready` is high. The block first divides a fixed constant by the period to get the frequency in hundredths of a megahertz. It then checks that frequency against an accepted band.

If the frequency lies in the band, it is doubled until it reaches the synthesizer's lower running limit, and each doubling doubles the post divider. The prescaled frequency is then scaled by the reference ratio and rounded to the nearest unit. After that it is offset and packed together with a post-divider code and two stop bits that are always set.

All three divisions share one restoring divider, which produces one quotient bit per cycle. When the result is ready, `done` pulses for one cycle together with the word, the chosen post divider and an error flag. These outputs hold their values until the next result. Shifting the word into the synthesizer is left to a neighbouring block.

Top module: `fwc_synth_word`

## Requirements
- R1: The frequency is the integer quotient of 100000000 divided by the requested period in ps, in units of 0.01 MHz.
- R2: A frequency above 15938 or below 1000 ends the request with `err`=1, `word`=0 and `post_div`=0 when `done` pulses.
- R3: A period of zero is not divided. It ends the request with `err`=1, `word`=0 and `post_div`=0.
- R4: While the frequency is below 8000 it is doubled. The post divider starts at 1 and doubles with it, so `post_div` is one of 1, 2, 4 or 8.
- R5: The scaled count is ((46 × f × 1000) / 1432 + 500) / 1000, where f is the prescaled frequency and every division truncates.
- R6: `word` bits 8:0 hold the scaled count minus 257.
- R7: `word` bits 10:9 give the post divider as a code: divider 1 → 2'b11, 2 → 2'b10, 4 → 2'b01, 8 → 2'b00.
- R8: `word` bits 12:11 are 2'b11 on every successful result.
- R9: `done` is high for exactly one cycle per request. `word`, `post_div` and `err` change only in a cycle where `done` is high.
- R10: While `ready` is low, `start` and `period_ps` are ignored, and the running request finishes with its own result. `ready` is high again in the cycle in which `done` pulses, and a request presented in that cycle is accepted.
- R11: After reset, `ready`=1, `done`=0, `err`=0, `word`=0 and `post_div`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only while `ready` is high |
| period_ps | input | 32 | Requested pixel-clock period in ps |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Last request was out of range or had a zero period |
| word | output | 13 | Synthesizer programming word |
| post_div | output | 4 | Chosen post divider (1, 2, 4 or 8) |

## Verification
The delicate overlap is the cycle in which `done` pulses. In that same cycle `ready` is already high again, so a following request can be taken while the previous result is still being presented. The bench provokes this by holding `start` high through a whole computation while `period_ps` carries a junk value. At the negedge where `done` is seen, it checks the first result against the first period and swaps in a second period, which the next edge must accept. The second result is then compared with the value computed in the bench from the second period alone, and that proves the junk value was ignored and that the hand-over lost nothing.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FREQ  = 2'd1,
      ST_SCALE = 2'd2,
      ST_ROUND = 2'd3
   } fwc_state_e;

endpackage

// File: rtl/fwc_divider.sv
// Restoring divider: one quotient bit per cycle, W cycles per division.
module fwc_divider #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quo
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q;
   logic [W-1:0]  quo_q;
   logic [W-1:0]  den_q;
   logic [CW-1:0] cnt_q;
   logic [W:0]    shifted;
   logic [W+1:0]  trial;
   logic          unused_bits;

   assign shifted     = {rem_q, quo_q[W-1]};
   assign trial       = {1'b0, shifted} - {2'b00, den_q};
   assign unused_bits = trial[W] ^ shifted[W];
   assign quo         = quo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         den_q <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            quo_q <= num;
            rem_q <= '0;
            den_q <= den;
            cnt_q <= CW'(W);
            busy  <= 1'b1;
         end else if (busy) begin
            if (!trial[W+1]) begin
               rem_q <= trial[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
               rem_q <= shifted[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fwc_prescale.sv
// Doubles the frequency up to MAX_SHIFT times while it stays below F_LOW.
module fwc_prescale #(
   parameter int W         = 32,
   parameter int F_LOW     = 8000,
   parameter int MAX_SHIFT = 3,
   parameter int SHIFT_W   = 2
) (
   input  logic [W-1:0]       f_in,
   output logic [W-1:0]       f_out,
   output logic [SHIFT_W-1:0] shift
);
   logic [W-1:0]       stage_f [MAX_SHIFT+1];
   logic [SHIFT_W-1:0] stage_s [MAX_SHIFT+1];

   assign stage_f[0] = f_in;
   assign stage_s[0] = '0;

   for (genvar i = 0; i < MAX_SHIFT; i++) begin : g_step
      logic low;
      assign low            = stage_f[i] < W'(F_LOW);
      assign stage_f[i + 1] = low ? (stage_f[i] << 1) : stage_f[i];
      assign stage_s[i + 1] = low ? (stage_s[i] + SHIFT_W'(1)) : stage_s[i];
   end

   assign f_out = stage_f[MAX_SHIFT];
   assign shift = stage_s[MAX_SHIFT];
endmodule

// File: rtl/fwc_pack.sv
// Packs offset count, post-divider code and stop bits into the word.
module fwc_pack #(
   parameter int W         = 32,
   parameter int MAX_SHIFT = 3,
   parameter int N_ADJ     = 257,
   parameter int LOW_W     = 9,
   parameter int SHIFT_W   = 2,
   parameter int STOP_W    = 2,
   parameter int WORD_W    = LOW_W + SHIFT_W + STOP_W
) (
   input  logic [W-1:0]       count,
   input  logic [SHIFT_W-1:0] shift,
   output logic [WORD_W-1:0]  word
);
   logic [W-1:0]       offset;
   logic [SHIFT_W-1:0] code;
   logic               unused_hi;

   assign offset    = count - W'(N_ADJ);
   assign code      = SHIFT_W'(MAX_SHIFT) - shift;
   assign unused_hi = ^offset[W-1:LOW_W];
   assign word      = {{STOP_W{1'b1}}, code, offset[LOW_W-1:0]};
endmodule

// File: rtl/fwc_synth_word.sv
module fwc_synth_word
   import fwc_pkg::*;
#(
   parameter int PERIOD_W  = 32,
   parameter int DIV_W     = 32,
   parameter int NUMER     = 100000000,
   parameter int F_MAX     = 15938,
   parameter int F_MIN     = 1000,
   parameter int F_LOW     = 8000,
   parameter int MAX_SHIFT = 3,
   parameter int REF_NUM   = 46,
   parameter int REF_DEN   = 1432,
   parameter int SCALE     = 1000,
   parameter int N_ADJ     = 257,
   parameter int LOW_W     = 9,
   localparam int SHIFT_W  = $clog2(MAX_SHIFT + 1),
   localparam int STOP_W   = 2,
   localparam int WORD_W   = LOW_W + SHIFT_W + STOP_W,
   localparam int PD_W     = MAX_SHIFT + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [PERIOD_W-1:0] period_ps,
   output logic                ready,
   output logic                done,
   output logic                err,
   output logic [WORD_W-1:0]   word,
   output logic [PD_W-1:0]     post_div
);
   localparam int SCALED_MUL = REF_NUM * SCALE;

   if (PERIOD_W > DIV_W) begin : g_bad_period_w
      $error("period width exceeds divider width");
   end
   if ((F_LOW >> MAX_SHIFT) > F_MIN) begin : g_bad_shift
      $error("post divider range cannot lift the lowest frequency");
   end
   if (!(F_MIN < F_LOW && F_LOW <= F_MAX)) begin : g_bad_band
      $error("frequency limits out of order");
   end
   if (longint'(F_MAX) * 2 * longint'(SCALED_MUL) >= (longint'(1) << DIV_W)) begin : g_bad_range
      $error("scaled numerator overflows the divider");
   end
   if (SHIFT_W != 2) begin : g_bad_code
      $error("post divider code must be two bits wide");
   end

   fwc_state_e         state_q;
   logic               div_go, div_busy, div_done;
   logic [DIV_W-1:0]   div_num, div_den, div_quo;
   logic [DIV_W-1:0]   pre_f;
   logic [SHIFT_W-1:0] pre_shift, shift_q;
   logic [WORD_W-1:0]  packed_word;
   logic               in_range;
   logic               unused_busy;

   assign unused_busy = div_busy;
   assign in_range    = (div_quo <= DIV_W'(F_MAX)) && (div_quo >= DIV_W'(F_MIN));
   assign ready       = (state_q == ST_IDLE);

   fwc_divider #(.W(DIV_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (div_go),
      .num  (div_num),
      .den  (div_den),
      .busy (div_busy),
      .done (div_done),
      .quo  (div_quo)
   );

   fwc_prescale #(
      .W(DIV_W), .F_LOW(F_LOW), .MAX_SHIFT(MAX_SHIFT), .SHIFT_W(SHIFT_W)
   ) u_pre (
      .f_in (div_quo),
      .f_out(pre_f),
      .shift(pre_shift)
   );

   fwc_pack #(
      .W(DIV_W), .MAX_SHIFT(MAX_SHIFT), .N_ADJ(N_ADJ), .LOW_W(LOW_W),
      .SHIFT_W(SHIFT_W), .STOP_W(STOP_W), .WORD_W(WORD_W)
   ) u_pack (
      .count(div_quo),
      .shift(shift_q),
      .word (packed_word)
   );

   always_comb begin
      div_go  = 1'b0;
      div_num = '0;
      div_den = '0;
      case (state_q)
         ST_IDLE: if (start && period_ps != '0) begin
            div_go  = 1'b1;
            div_num = DIV_W'(NUMER);
            div_den = DIV_W'(period_ps);
         end
         ST_FREQ: if (div_done && in_range) begin
            div_go  = 1'b1;
            div_num = pre_f * DIV_W'(SCALED_MUL);
            div_den = DIV_W'(REF_DEN);
         end
         ST_SCALE: if (div_done) begin
            div_go  = 1'b1;
            div_num = div_quo + DIV_W'(SCALE / 2);
            div_den = DIV_W'(SCALE);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         shift_q  <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         word     <= '0;
         post_div <= '0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               if (period_ps == '0) begin
                  done     <= 1'b1;
                  err      <= 1'b1;
                  word     <= '0;
                  post_div <= '0;
               end else begin
                  state_q <= ST_FREQ;
               end
            end
            ST_FREQ: if (div_done) begin
               if (in_range) begin
                  shift_q <= pre_shift;
                  state_q <= ST_SCALE;
               end else begin
                  done     <= 1'b1;
                  err      <= 1'b1;
                  word     <= '0;
                  post_div <= '0;
                  state_q  <= ST_IDLE;
               end
            end
            ST_SCALE: if (div_done) state_q <= ST_ROUND;
            ST_ROUND: if (div_done) begin
               done     <= 1'b1;
               err      <= 1'b0;
               word     <= packed_word;
               post_div <= PD_W'(1) << shift_q;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fwc_check.sv
module fwc_check #(
   parameter int LOW_W  = 9,
   parameter int WORD_W = 13,
   parameter int PD_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic              done,
   input logic              err,
   input logic [WORD_W-1:0] word,
   input logic [PD_W-1:0]   post_div
);
   logic [1:0] code;
   assign code = word[LOW_W +: 2];

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (done || ($stable(word) && $stable(post_div) && $stable(err))));

   // R2
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (word == '0 && post_div == '0));

   // R8
   stop_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (word[WORD_W-1 -: 2] == 2'b11));

   // R4
   post_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> ($countones(post_div) == 1));

   // R7
   code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> ((post_div[0] && code == 2'd3) || (post_div[1] && code == 2'd2) ||
                          (post_div[2] && code == 2'd1) || (post_div[3] && code == 2'd0)));

   // R10
   ready_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);
endmodule

bind fwc_synth_word fwc_check #(
   .LOW_W(LOW_W), .WORD_W(WORD_W), .PD_W(PD_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ready   (ready),
   .done    (done),
   .err     (err),
   .word    (word),
   .post_div(post_div)
);

// File: tb/sim_fwc_synth_word.sv
`timescale 1ns/1ps
module sim_fwc_synth_word;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] period_ps = '0;
   logic        ready, done, err;
   logic [12:0] word;
   logic [3:0]  post_div;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   fwc_synth_word u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .period_ps(period_ps),
      .ready(ready), .done(done), .err(err), .word(word), .post_div(post_div)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected result from the requirements (R1..R7 arithmetic).
   task automatic model(input longint p, output bit e, output longint w, output longint pd);
      longint f, c, code;
      e = 1'b1; w = 0; pd = 0;
      if (p == 0) return;
      f = 100000000 / p;
      if (f > 15938 || f < 1000) return;
      pd = 1;
      while (f < 8000) begin f = f * 2; pd = pd * 2; end
      c = ((46 * f * 1000) / 1432 + 500) / 1000;
      code = (pd == 1) ? 3 : (pd == 2) ? 2 : (pd == 4) ? 1 : 0;
      w = ((c - 257) & 'h1ff) | (code << 9) | 'h1800;
      e = 1'b0;
   endtask

   task automatic check_result(input longint p);
      bit e; longint w, pd;
      model(p, e, w, pd);
      if (p == 0) chk(err == e, "R3 err", err, e);
      else        chk(err == e, "R2 err", err, e);
      if (e) begin
         chk(word == 0 && post_div == 0, "R2 R3 cleared", {post_div, word}, 0);
      end else begin
         chk(word[8:0] == w[8:0], "R1 R5 R6 low field", word[8:0], w[8:0]);
         chk(word[10:9] == w[10:9], "R7 code", word[10:9], w[10:9]);
         chk(word[12:11] == 2'b11, "R8 stop bits", word[12:11], 3);
         chk(post_div == pd, "R4 post_div", post_div, pd);
      end
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic run_req(input longint p);
      @(negedge clk);
      while (!ready) @(negedge clk);
      period_ps = 32'(p);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check_result(p);
      @(negedge clk);
      chk(!done, "R9 single pulse", done, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(ready == 1 && done == 0 && err == 0 && word == 0 && post_div == 0,
          "R11 reset", {ready, done, err, post_div, word}, {1'b1, 18'd0});
      rst_n = 1'b1;
      @(negedge clk);

      // Boundary periods: zero, band edges, divider steps.
      run_req(0);
      run_req(6274);
      run_req(6273);
      run_req(100000);
      run_req(100001);
      run_req(12500);
      run_req(12501);
      run_req(25000);
      run_req(25001);
      run_req(50000);
      run_req(50001);
      run_req(99999);
      run_req(32'hFFFF_FFFF);
      run_req(1);

      // Sweep across the accepted band and beyond.
      for (longint p = 6000; p <= 101000; p += 157) run_req(p);

      // R10: start held with junk while busy, then hand-over in the done cycle.
      @(negedge clk);
      while (!ready) @(negedge clk);
      period_ps = 32'd13333;
      start = 1'b1;
      @(negedge clk);
      chk(!ready, "R10 busy after accept", ready, 0);
      period_ps = 32'd7000;
      wait_done();
      chk(ready, "R10 ready in done cycle", ready, 1);
      check_result(13333);
      period_ps = 32'd41000;
      @(negedge clk);
      start = 1'b0;
      chk(!ready, "R10 accepted in done cycle", ready, 0);
      wait_done();
      check_result(41000);

      // R9: outputs hold after the pulse.
      repeat (5) @(negedge clk);
      check_result(41000);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule